// File: doc/BRIEF.md
# Load-Reserve Store-Conditional Tracker

This block holds a single processor reservation so that a load-and-reserve followed by a store-conditional behaves as one atomic read-modify-write. A reservation names an aligned 32-byte granule of the address space. A load-and-reserve records its granule. A later store-conditional to the same granule may write only while that reservation is still in place. A write by another master, reported on the snoop inputs, cancels the reservation when it lands in the reserved granule.

Each request comes with the storage attributes of its page and with fault flags from translation. A page that is cacheable and write-through, or a protection or page fault, raises a data-storage exception request. A request that is not word-aligned raises an alignment error instead. Any request that takes an exception leaves the reservation as it was. The store permission is combinational in the cycle of the request. The success flag, the completion strobe and both exception outputs are registered and appear in the following cycle. The block performs no memory write itself.

Top module: `lrsc_tracker`

## Requirements
- R1: The granule of an address is its bits [ADDR_W-1:5]. A store-conditional to any word inside the reserved 32-byte granule matches the reservation.
- R2: An accepted load-and-reserve (`req_valid`=1, `req_is_sc`=0) records its granule. An accepted store-conditional (`req_is_sc`=1) to a held, matching granule drives `store_go` high in the same cycle.
- R3: A request with `attr_wt`=1 and `attr_ci`=0 raises `dsi_req` one cycle later. `attr_coh` has no effect, and `attr_wt`=1 with `attr_ci`=1 raises nothing.
- R4: A request with `fault_prot`=1 or `fault_page`=1 raises `dsi_req` one cycle later.
- R5: Every accepted store-conditional clears the reservation, whether it passes or fails.
- R6: For every accepted store-conditional, `sc_done` is high in the next cycle. `sc_pass` is high in that cycle only if `store_go` was high, and it is never high without `sc_done`.
- R7: A snoop (`snoop_valid`=1) whose granule equals the reserved granule clears the reservation. A snoop to any other granule does not. A snoop to the reserved granule in the same cycle as a store-conditional makes that store-conditional fail.
- R8: A store-conditional whose granule differs from the reserved granule fails and does not raise `store_go`.
- R9: A request with `req_addr[1:0]`≠0 raises `align_err` one cycle later, does not raise `dsi_req` even when its attributes would, and does not raise `store_go`.
- R10: A request that raises `dsi_req` or `align_err` leaves the reservation unchanged: a load-and-reserve does not replace it, and a store-conditional neither clears it nor reports `sc_done`.
- R11: A load-and-reserve replaces any older reservation. When a snoop hits in the same cycle as a load-and-reserve, the new reservation is set.
- R12: After reset there is no reservation, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_sc | input | 1 | 1 = store-conditional, 0 = load-and-reserve |
| req_addr | input | ADDR_W | Effective byte address of the request |
| attr_wt | input | 1 | Page is write-through |
| attr_ci | input | 1 | Page is caching-inhibited |
| attr_coh | input | 1 | Page requires coherence (does not affect the decision) |
| fault_prot | input | 1 | Protection violation on this access |
| fault_page | input | 1 | Page fault on this access |
| snoop_valid | input | 1 | Another master writes this cycle |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| store_go | output | 1 | Store-conditional may perform its store (same cycle) |
| sc_done | output | 1 | A store-conditional completed in the previous cycle |
| sc_pass | output | 1 | Success flag for that store-conditional |
| dsi_req | output | 1 | Data-storage exception request for the previous cycle's request |
| align_err | output | 1 | Alignment error for the previous cycle's request |

## Verification
`store_go` belongs to the request cycle. `sc_done`, `sc_pass`, `dsi_req` and `align_err` belong to the cycle after it, because each passes through one register. The bench drives each request after a falling edge and samples half a phase later. At that point `store_go` is compared with the model's view of the current request. The registered outputs are compared with what the model stored at the previous rising edge. The reservation itself is never read directly. Its state after an exception, a snoop or a store-conditional is shown by the result of the next store-conditional.

// File: rtl/lrsc_tracker.sv
module lrsc_tracker #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              attr_wt,
  input  logic              attr_ci,
  input  logic              attr_coh,
  input  logic              fault_prot,
  input  logic              fault_page,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              store_go,
  output logic              sc_done,
  output logic              sc_pass,
  output logic              dsi_req,
  output logic              align_err
);
  localparam int GW = ADDR_W - GRAN_LSB;

  logic          resv_valid;
  logic [GW-1:0] resv_gran;

  logic [GW-1:0] req_gran, snp_gran;
  logic          misal, dsi_hit, accept, snoop_kill, held;

  assign req_gran   = req_addr[ADDR_W-1:GRAN_LSB];
  assign snp_gran   = snoop_addr[ADDR_W-1:GRAN_LSB];

  assign misal      = req_valid && (req_addr[1:0] != 2'b00);
  assign dsi_hit    = req_valid && !misal &&
                      ((attr_wt && !attr_ci) || fault_prot || fault_page);
  assign accept     = req_valid && !misal && !dsi_hit;

  assign snoop_kill = snoop_valid && resv_valid && (snp_gran == resv_gran);
  assign held       = resv_valid && !snoop_kill && (req_gran == resv_gran);
  assign store_go   = accept && req_is_sc && held;

  logic unused_bits;
  assign unused_bits = ^{attr_coh, req_addr[GRAN_LSB-1:2], snoop_addr[GRAN_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_gran  <= '0;
    end else if (accept && !req_is_sc) begin
      resv_valid <= 1'b1;
      resv_gran  <= req_gran;
    end else if ((accept && req_is_sc) || snoop_kill) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done   <= 1'b0;
      sc_pass   <= 1'b0;
      dsi_req   <= 1'b0;
      align_err <= 1'b0;
    end else begin
      sc_done   <= accept && req_is_sc;
      sc_pass   <= store_go;
      dsi_req   <= dsi_hit;
      align_err <= misal;
    end
  end
endmodule

// File: rtl/lrsc_tracker_chk.sv
module lrsc_tracker_chk #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_is_sc,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       attr_wt,
  input logic                       attr_ci,
  input logic                       snoop_valid,
  input logic                       store_go,
  input logic                       sc_done,
  input logic                       sc_pass,
  input logic                       dsi_req,
  input logic                       align_err,
  input logic                       resv_valid,
  input logic [ADDR_W-GRAN_LSB-1:0] resv_gran
);
  a_r2_go_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> (resv_valid && req_valid && req_is_sc));

  a_r3_wt_raises_dsi: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] == 2'b00 && attr_wt && !attr_ci) |=> (dsi_req && !sc_done));

  a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> !resv_valid);

  a_r6_flag_next: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> (sc_done && sc_pass));

  a_r6_pass_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_done);

  a_r9_misal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00 && !snoop_valid)
      |=> ($stable(resv_valid) && $stable(resv_gran) && align_err && !dsi_req));
endmodule

bind lrsc_tracker lrsc_tracker_chk #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
  .req_addr(req_addr), .attr_wt(attr_wt), .attr_ci(attr_ci),
  .snoop_valid(snoop_valid), .store_go(store_go), .sc_done(sc_done),
  .sc_pass(sc_pass), .dsi_req(dsi_req), .align_err(align_err),
  .resv_valid(resv_valid), .resv_gran(resv_gran)
);

// File: tb/tb_lrsc_tracker.sv
module tb_lrsc_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_is_sc = 0;
  logic [31:0] req_addr = '0, snoop_addr = '0;
  logic        attr_wt = 0, attr_ci = 0, attr_coh = 0;
  logic        fault_prot = 0, fault_page = 0, snoop_valid = 0;
  logic        store_go, sc_done, sc_pass, dsi_req, align_err;

  always #10 clk = ~clk;

  lrsc_tracker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
    .req_addr(req_addr), .attr_wt(attr_wt), .attr_ci(attr_ci), .attr_coh(attr_coh),
    .fault_prot(fault_prot), .fault_page(fault_page), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .store_go(store_go), .sc_done(sc_done),
    .sc_pass(sc_pass), .dsi_req(dsi_req), .align_err(align_err)
  );

  int checks = 0, errors = 0;
  bit m_has = 0;
  longint unsigned m_blk = 0;
  bit e_done = 0, e_pass = 0, e_dsi = 0, e_align = 0;

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit v, bit sc, logic [31:0] a,
                     bit wt = 0, bit ci = 0, bit coh = 0, bit fp = 0, bit fg = 0,
                     bit sv = 0, logic [31:0] sa = 0);
    bit mis, exc, acc, kill, go;
    @(negedge clk);
    req_valid = v; req_is_sc = sc; req_addr = a;
    attr_wt = wt; attr_ci = ci; attr_coh = coh; fault_prot = fp; fault_page = fg;
    snoop_valid = sv; snoop_addr = sa;
    #5;
    mis  = v && (a % 4 != 0);
    exc  = v && !mis && ((wt && !ci) || fp || fg);
    acc  = v && !mis && !exc;
    kill = sv && m_has && (sa / 32 == m_blk);
    go   = acc && sc && m_has && !kill && (a / 32 == m_blk);
    chk(tag, "store_go", store_go, go);
    chk(tag, "sc_done", sc_done, e_done);
    chk(tag, "sc_pass", sc_pass, e_pass);
    chk(tag, "dsi_req", dsi_req, e_dsi);
    chk(tag, "align_err", align_err, e_align);
    @(posedge clk);
    e_done = acc && sc; e_pass = go; e_dsi = exc; e_align = mis;
    if (acc && !sc) begin m_has = 1; m_blk = a / 32; end
    else if ((acc && sc) || kill) m_has = 0;
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R12", "store_go", store_go, 0); chk("R12", "sc_done", sc_done, 0);
    chk("R12", "dsi_req", dsi_req, 0);   chk("R12", "align_err", align_err, 0);
    @(negedge clk); rst_n = 1;
    idle("R12");
    cyc("R12", 1, 1, 32'h100);             // no reservation after reset
    cyc("R2", 1, 0, 32'h1000);
    cyc("R2", 1, 1, 32'h1004);
    cyc("R5", 1, 1, 32'h1000);             // second SC fails
    cyc("R1", 1, 0, 32'h2000);
    cyc("R1", 1, 1, 32'h201C);
    cyc("R8", 1, 0, 32'h2000);
    cyc("R8", 1, 1, 32'h2020);
    cyc("R7", 1, 0, 32'h3000);
    cyc("R7", 0, 0, 32'h0, 0, 0, 0, 0, 0, 1, 32'h3010);
    cyc("R7", 1, 1, 32'h3000);
    cyc("R7", 1, 0, 32'h3000);
    cyc("R7", 0, 0, 32'h0, 0, 0, 0, 0, 0, 1, 32'h4000);
    cyc("R7", 1, 1, 32'h3000);
    cyc("R7", 1, 0, 32'h3000);
    cyc("R7", 1, 1, 32'h3000, 0, 0, 0, 0, 0, 1, 32'h3008);
    cyc("R11", 1, 0, 32'h5000, 0, 0, 0, 0, 0, 1, 32'h5004);
    cyc("R11", 1, 1, 32'h5000);
    cyc("R11", 1, 0, 32'h5000);
    cyc("R11", 1, 0, 32'h6000);
    cyc("R11", 1, 1, 32'h5000);
    cyc("R3", 1, 0, 32'h7000);
    cyc("R3", 1, 0, 32'h8000, 1, 0, 1);
    cyc("R10", 1, 1, 32'h7000);            // old reservation survived
    cyc("R10", 1, 0, 32'h7000);
    cyc("R10", 1, 1, 32'h7000, 1, 0, 0);   // excepting SC does not clear
    cyc("R10", 1, 1, 32'h7000);
    cyc("R3", 1, 0, 32'h7100, 1, 1, 1);    // wt+ci: no exception
    cyc("R3", 1, 1, 32'h7104, 0, 0, 0);
    cyc("R4", 1, 0, 32'h9000, 0, 0, 0, 1, 0);
    cyc("R4", 1, 1, 32'h9000, 0, 0, 0, 0, 1);
    cyc("R9", 1, 0, 32'h9000);
    cyc("R9", 1, 0, 32'hA002, 1, 0, 0, 1, 1);
    cyc("R9", 1, 1, 32'h9001);
    cyc("R9", 1, 1, 32'h9003, 0, 0, 0, 0, 0, 1, 32'h5000);
    cyc("R9", 1, 1, 32'h9000);
    for (int i = 0; i < 8; i++) begin
      cyc("R1", 1, 0, 32'h10000 + i * 64 + (i % 8) * 4);
      cyc("R2", 1, 1, 32'h10000 + i * 64 + ((7 - i) % 8) * 4);
      if (i % 2 == 0) cyc("R5", 1, 1, 32'h10000 + i * 64);
    end
    cyc("R7", 0, 0, 32'h0, 0, 0, 0, 0, 0, 1, 32'h10000);
    idle("R6");
    idle("R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule